// File: doc/BRIEF.md
# Byte Parity Generator and Checker

This block handles the parity for a 16-bit word carried as two bytes between two sides, A and B. Each byte has its own parity bit: the low byte (bits 7..0) goes with parity bit 0 and the high byte (bits 15..8) goes with parity bit 1. Going from A to B, a mode input selects one of two behaviours. In the first, the block creates fresh parity from the A data. In the second, it checks the parity bits that arrived with the A data. Going from B to A, the block only ever checks. One odd/even select sets the sense of parity for both directions.

Each direction has one error indication, which is the OR of its two byte errors. The indication is gated by that direction's active-low output enable, so it can be held off while data is settling. The open-drain error line is modelled logically. The block raises a request to pull a shared active-low line low, and any number of such requests can be wire-ANDed onto one error or interrupt line. All outputs are registered once. A result therefore reflects the inputs captured at the previous rising clock edge.

Top module: `bytepar_top`

## Requirements
- R1: With `oddSel`=1 and `genSel`=1, each generated bit `parOutB[k]` makes the count of ones across byte k of `dataA` plus that bit odd. Byte 0 is `dataA[7:0]` and byte 1 is `dataA[15:8]`.
- R2: With `oddSel`=0 and `genSel`=1, each generated bit `parOutB[k]` makes that 9-bit count even.
- R3: With `genSel`=1, `parInA` has no effect: `parOutB` depends only on `dataA` and `oddSel`, and `pullAbLo` stays 0.
- R4: With `genSel`=0, `parOutB` equals the received `parInA`, bit for bit.
- R5: With `genSel`=0 and `oeAbN`=0, `pullAbLo` is 1 exactly when at least one A byte and its `parInA` bit have the wrong parity sense for `oddSel`.
- R6: The B-to-A direction checks in both settings of `genSel`. With `oeBaN`=0, `pullBaLo` is 1 exactly when at least one B byte and its `parInB` bit have the wrong sense for `oddSel`. `parOutA` always equals the received `parInB`.
- R7: While `oeAbN`=1, `pullAbLo` is 0. While `oeBaN`=1, `pullBaLo` is 0.
- R8: While `rstN`=0, every output is 0. Every output changes only at a rising clock edge and reflects the inputs sampled at that edge.
- R9: When the error requests of several instances are wire-ANDed as line = NOT(OR of the requests), the line is low whenever any one instance requests.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; outputs update on the rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| genSel | input | 1 | A-to-B mode: 1 generates parity, 0 checks it |
| oddSel | input | 1 | Parity sense for both directions: 1 odd, 0 even |
| oeAbN | input | 1 | Active-low enable of the A-to-B error request |
| oeBaN | input | 1 | Active-low enable of the B-to-A error request |
| dataA | input | 16 | Word arriving from side A |
| parInA | input | 2 | Parity bits arriving with `dataA`, one per byte |
| dataB | input | 16 | Word arriving from side B |
| parInB | input | 2 | Parity bits arriving with `dataB`, one per byte |
| parOutB | output | 2 | Parity bits sent toward side B |
| parOutA | output | 2 | Parity bits sent toward side A |
| pullAbLo | output | 1 | Request to pull the A-to-B error line low |
| pullBaLo | output | 1 | Request to pull the B-to-A error line low |

## Verification
Every result of this block is due exactly one rising edge after its inputs are presented. This applies to the two parity buses as well as the two error requests, since all of them leave through the same register stage. The driver sets a new input vector at each falling edge and pushes the expected outputs for that vector. The monitor pops that item one time unit after the next rising edge, so each comparison sees the register contents for that vector and no later ones. A separate probe just before a rising edge confirms that the outputs still hold the previous vector's results. The wire-ANDed line is rebuilt in the bench from two instances and checked on the same schedule.

// File: rtl/bytepar_pkg.sv
package bytepar_pkg;
  typedef struct packed {
    logic genActive;
    logic oddActive;
    logic abFlagEn;
    logic baFlagEn;
  } parCtrl_t;
endpackage

// File: rtl/bytepar_ctrl.sv
module bytepar_ctrl
  import bytepar_pkg::*;
(
  input  logic     genSel,
  input  logic     oddSel,
  input  logic     oeAbN,
  input  logic     oeBaN,
  output parCtrl_t ctrl
);
  always_comb begin
    ctrl.genActive = genSel;
    ctrl.oddActive = oddSel;
    ctrl.abFlagEn  = ~oeAbN;
    ctrl.baFlagEn  = ~oeBaN;
  end
endmodule

// File: rtl/bytepar_dpath.sv
module bytepar_dpath
  import bytepar_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  parCtrl_t                 ctrl,
  input  logic [DATA_W-1:0]        dataA,
  input  logic [DATA_W/BYTE_W-1:0] parInA,
  input  logic [DATA_W-1:0]        dataB,
  input  logic [DATA_W/BYTE_W-1:0] parInB,
  output logic [DATA_W/BYTE_W-1:0] parOutB,
  output logic [DATA_W/BYTE_W-1:0] parOutA,
  output logic                     pullAbLo,
  output logic                     pullBaLo
);
  localparam int NB = DATA_W / BYTE_W;

  logic [NB-1:0] sumA, sumB, genBits, errAbByte, errBaByte;

  for (genvar i = 0; i < NB; i++) begin : g_byte
    assign sumA[i]      = ^dataA[i*BYTE_W +: BYTE_W];
    assign sumB[i]      = ^dataB[i*BYTE_W +: BYTE_W];
    // a set bit turns the sum into the selected sense
    assign genBits[i]   = sumA[i] ^ ctrl.oddActive;
    assign errAbByte[i] = ~ctrl.genActive & (sumA[i] ^ parInA[i] ^ ctrl.oddActive);
    assign errBaByte[i] = sumB[i] ^ parInB[i] ^ ctrl.oddActive;
  end

  logic [NB-1:0] nextParB;
  logic          nextAb, nextBa;

  always_comb begin
    nextParB = ctrl.genActive ? genBits : parInA;
    nextAb   = ctrl.abFlagEn & (|errAbByte);
    nextBa   = ctrl.baFlagEn & (|errBaByte);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      parOutB  <= '0;
      parOutA  <= '0;
      pullAbLo <= 1'b0;
      pullBaLo <= 1'b0;
    end else begin
      parOutB  <= nextParB;
      parOutA  <= parInB;
      pullAbLo <= nextAb;
      pullBaLo <= nextBa;
    end
  end
endmodule

// File: rtl/bytepar_top.sv
module bytepar_top
  import bytepar_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     genSel,
  input  logic                     oddSel,
  input  logic                     oeAbN,
  input  logic                     oeBaN,
  input  logic [DATA_W-1:0]        dataA,
  input  logic [DATA_W/BYTE_W-1:0] parInA,
  input  logic [DATA_W-1:0]        dataB,
  input  logic [DATA_W/BYTE_W-1:0] parInB,
  output logic [DATA_W/BYTE_W-1:0] parOutB,
  output logic [DATA_W/BYTE_W-1:0] parOutA,
  output logic                     pullAbLo,
  output logic                     pullBaLo
);
  parCtrl_t ctrl;

  bytepar_ctrl u_ctrl (
    .genSel(genSel),
    .oddSel(oddSel),
    .oeAbN (oeAbN),
    .oeBaN (oeBaN),
    .ctrl  (ctrl)
  );

  bytepar_dpath #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .dataA   (dataA),
    .parInA  (parInA),
    .dataB   (dataB),
    .parInB  (parInB),
    .parOutB (parOutB),
    .parOutA (parOutA),
    .pullAbLo(pullAbLo),
    .pullBaLo(pullBaLo)
  );
endmodule

// File: rtl/bytepar_chk.sv
module bytepar_chk #(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     genSel,
  input logic                     oddSel,
  input logic                     oeAbN,
  input logic                     oeBaN,
  input logic [DATA_W-1:0]        dataA,
  input logic [DATA_W/BYTE_W-1:0] parInA,
  input logic [DATA_W-1:0]        dataB,
  input logic [DATA_W/BYTE_W-1:0] parInB,
  input logic [DATA_W/BYTE_W-1:0] parOutB,
  input logic [DATA_W/BYTE_W-1:0] parOutA,
  input logic                     pullAbLo,
  input logic                     pullBaLo
);
  localparam int NB = DATA_W / BYTE_W;

  always_comb begin
    if (!rstN) begin
      a_r8_reset_clear: assert (parOutB == '0 && parOutA == '0 && !pullAbLo && !pullBaLo);
    end
  end

  a_r3_gen_no_flag: assert property (@(posedge clk) disable iff (!rstN)
    genSel |=> !pullAbLo);
  a_r7_ab_gated: assert property (@(posedge clk) disable iff (!rstN)
    oeAbN |=> !pullAbLo);
  a_r7_ba_gated: assert property (@(posedge clk) disable iff (!rstN)
    oeBaN |=> !pullBaLo);
  a_r4_pass_b: assert property (@(posedge clk) disable iff (!rstN)
    !genSel |=> parOutB == $past(parInA));
  a_r6_pass_a: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> parOutA == $past(parInB));

  for (genvar i = 0; i < NB; i++) begin : g_chk
    // R1 and R2: generated bit gives the chosen sense over the 9 bits
    a_r1_gen_sense: assert property (@(posedge clk) disable iff (!rstN)
      genSel |=> ((^$past(dataA[i*BYTE_W +: BYTE_W])) ^ parOutB[i]) == $past(oddSel));
    a_r5_ab_err: assert property (@(posedge clk) disable iff (!rstN)
      (!genSel && !oeAbN && (((^dataA[i*BYTE_W +: BYTE_W]) ^ parInA[i]) != oddSel))
      |=> pullAbLo);
    a_r6_ba_err: assert property (@(posedge clk) disable iff (!rstN)
      (!oeBaN && (((^dataB[i*BYTE_W +: BYTE_W]) ^ parInB[i]) != oddSel))
      |=> pullBaLo);
  end
endmodule

bind bytepar_top bytepar_chk #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_chk (.*);

// File: tb/bytepar_top_bench.sv
module bytepar_top_bench;
  localparam int DW = 16;
  localparam int NB = 2;

  typedef struct {
    logic [NB-1:0] parB;
    logic [NB-1:0] parA;
    logic          ab;
    logic          ba;
    logic          line;
    string         tag;
  } exp_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic genSel = 1'b0, oddSel = 1'b0, oeAbN = 1'b1, oeBaN = 1'b1;
  logic [DW-1:0] dataA = '0, dataB = '0, peerDataB = '0;
  logic [NB-1:0] parInA = '0, parInB = '0, peerParB = '0;
  logic [NB-1:0] parOutB, parOutA, peerOutB, peerOutA;
  logic pullAbLo, pullBaLo, peerAb, peerBa;
  logic baLine;

  int nChecks = 0;
  int nFails = 0;
  exp_t sb[$];
  exp_t lastExp;
  logic haveLast = 1'b0;

  always #5 clk = ~clk;

  assign baLine = ~(pullBaLo | peerBa);

  bytepar_top u_bytepar_top (
    .clk(clk), .rstN(rstN), .genSel(genSel), .oddSel(oddSel),
    .oeAbN(oeAbN), .oeBaN(oeBaN), .dataA(dataA), .parInA(parInA),
    .dataB(dataB), .parInB(parInB), .parOutB(parOutB), .parOutA(parOutA),
    .pullAbLo(pullAbLo), .pullBaLo(pullBaLo)
  );

  bytepar_top u_peer (
    .clk(clk), .rstN(rstN), .genSel(genSel), .oddSel(oddSel),
    .oeAbN(oeAbN), .oeBaN(oeBaN), .dataA(dataA), .parInA(parInA),
    .dataB(peerDataB), .parInB(peerParB), .parOutB(peerOutB), .parOutA(peerOutA),
    .pullAbLo(peerAb), .pullBaLo(peerBa)
  );

  function automatic logic goodBit(input logic [7:0] b, input logic odd);
    if (($countones(b) % 2) == 1) return !odd;
    return odd;
  endfunction

  function automatic logic anyBad(input logic [DW-1:0] d, input logic [NB-1:0] p,
                                  input logic odd);
    logic bad = 1'b0;
    for (int k = 0; k < NB; k++)
      if (p[k] != goodBit(d[k*8 +: 8], odd)) bad = 1'b1;
    return bad;
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input string tag, input logic g, input logic o,
                       input logic eab, input logic eba,
                       input logic [DW-1:0] da, input logic [NB-1:0] pa,
                       input logic [DW-1:0] db, input logic [NB-1:0] pb,
                       input logic [DW-1:0] qdb, input logic [NB-1:0] qpb);
    exp_t e;
    @(negedge clk);
    genSel = g; oddSel = o; oeAbN = eab; oeBaN = eba;
    dataA = da; parInA = pa; dataB = db; parInB = pb;
    peerDataB = qdb; peerParB = qpb;
    for (int k = 0; k < NB; k++)
      e.parB[k] = g ? goodBit(da[k*8 +: 8], o) : pa[k];
    e.parA = pb;
    e.ab   = !g && !eab && anyBad(da, pa, o);
    e.ba   = !eba && anyBad(db, pb, o);
    e.line = !(e.ba || (!eba && anyBad(qdb, qpb, o)));
    e.tag  = tag;
    sb.push_back(e);
  endtask

  always @(posedge clk) begin
    #1;
    if (rstN && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check(e.tag, "parOutB", int'(parOutB), int'(e.parB));
      check(e.tag, "parOutA", int'(parOutA), int'(e.parA));
      check(e.tag, "pullAbLo", int'(pullAbLo), int'(e.ab));
      check(e.tag, "pullBaLo", int'(pullBaLo), int'(e.ba));
      check(e.tag, "baLine", int'(baLine), int'(e.line));
      lastExp = e;
      haveLast = 1'b1;
    end
  end

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    check("R8", "reset parOutB", int'(parOutB), 0);
    check("R8", "reset parOutA", int'(parOutA), 0);
    check("R8", "reset flags", int'({pullAbLo, pullBaLo}), 0);
    rstN = 1'b1;

    // R1: odd generate
    drive("R1", 1, 1, 0, 1, 16'h0000, 2'b00, '0, 2'b00, '0, 2'b00);
    drive("R1", 1, 1, 0, 1, 16'hFFFF, 2'b00, '0, 2'b00, '0, 2'b00);
    drive("R1", 1, 1, 0, 1, 16'h0100, 2'b00, '0, 2'b00, '0, 2'b00);
    drive("R1", 1, 1, 0, 1, 16'hA5C3, 2'b00, '0, 2'b00, '0, 2'b00);
    // R2: even generate
    drive("R2", 1, 0, 0, 1, 16'h0001, 2'b00, '0, 2'b00, '0, 2'b00);
    drive("R2", 1, 0, 0, 1, 16'h7F80, 2'b00, '0, 2'b00, '0, 2'b00);
    // R3: parInA ignored in generate mode, no flag even with bad bits
    drive("R3", 1, 1, 0, 1, 16'h1234, 2'b11, '0, 2'b00, '0, 2'b00);
    drive("R3", 1, 1, 0, 1, 16'h1234, 2'b00, '0, 2'b00, '0, 2'b00);
    // R4/R5: check mode, good then bad bytes
    drive("R4", 0, 1, 0, 1, 16'h0000, 2'b11, '0, 2'b00, '0, 2'b00);
    drive("R5", 0, 1, 0, 1, 16'h0000, 2'b10, '0, 2'b00, '0, 2'b00);
    drive("R5", 0, 1, 0, 1, 16'h0000, 2'b01, '0, 2'b00, '0, 2'b00);
    drive("R5", 0, 0, 0, 1, 16'h0301, 2'b00, '0, 2'b00, '0, 2'b00);
    drive("R5", 0, 0, 0, 1, 16'h0301, 2'b11, '0, 2'b00, '0, 2'b00);
    // R7: enables high suppress flags with bad parity
    drive("R7", 0, 1, 1, 1, 16'h0000, 2'b00, 16'h0000, 2'b00, '0, 2'b11);
    // R6: B-to-A checks in both modes
    drive("R6", 1, 1, 1, 0, '0, 2'b00, 16'h0000, 2'b01, '0, 2'b11);
    drive("R6", 0, 1, 1, 0, '0, 2'b00, 16'h8000, 2'b01, '0, 2'b11);
    drive("R6", 0, 0, 1, 0, '0, 2'b00, 16'h0100, 2'b10, '0, 2'b00);
    drive("R6", 1, 0, 1, 0, '0, 2'b00, 16'h00FF, 2'b01, '0, 2'b00);
    // R9: only the peer has an error, shared line must still go low
    drive("R9", 1, 1, 1, 0, '0, 2'b00, 16'h0000, 2'b11, 16'h0000, 2'b01);
    drive("R9", 1, 1, 1, 0, '0, 2'b00, 16'h0000, 2'b11, 16'h0000, 2'b11);

    // R8: output holds until the next edge
    wait (sb.size() == 0);
    @(negedge clk);
    genSel = 0; oddSel = 1; oeAbN = 0; parInA = 2'b00; dataA = 16'h0000;
    #3;
    check("R8", "hold pullAbLo", int'(pullAbLo), int'(haveLast ? lastExp.ab : 1'b0));
    check("R8", "hold parOutB", int'(parOutB), int'(haveLast ? lastExp.parB : 2'b00));
    @(posedge clk);
    #1;
    check("R8", "after edge pullAbLo", int'(pullAbLo), 1);

    @(negedge clk);
    finishRun();
  end
endmodule